// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

A watchdog peripheral for a system clock domain. A slow-clock enable pulse feeds a prescaler, and the prescaler's wrap decrements a 12-bit down-counter. Software keeps the system alive by sending a restart command that carries an 8-bit key. A window value limits how early a restart is allowed: a restart that arrives while the counter is still above the window counts as a fault. If the counter underflows, that is also a fault. A fault raises an interrupt level, a one-cycle reset request, or both. Either halt input (debug or idle) can freeze the count if the mode register enables it.

Software reaches three word registers through a simple word-addressed read/write port:

| Word | Register |
|------|----------|
| 0 | command |
| 1 | mode |
| 2 | status |

The status word also carries the live counter value. Two writes to the command or mode register must be spaced apart. A write that comes too soon is dropped.

Top module: `wdg_top`

## Requirements
- R1: After reset, irq_o and rst_req_o are low and status reads 0x0FFF0000 (counter 0xFFF, both flags clear). Mode reads 0x0FFF0FFF: reload 0xFFF, window 0xFFF, watchdog enabled, fault interrupt off, fault reset off, no halts.
- R2: While the watchdog runs, the counter decreases by one on every PRESC_DIV-th slow tick. The tick count starts from zero at each reload.
- R3: A write to word 0 is a restart only when wdata_i[31:24] is 0xA5 and wdata_i[0] is 1. Any other word-0 write changes nothing, including the write spacing.
- R4: A restart while the counter is above the window value (mode bits 27:16) sets status bit 1 and does not reload. A restart at or below the window reloads the counter from mode bits 11:0.
- R5: A window value of 0xFFF disables the window check, so a restart is accepted at any count.
- R6: A decrement at count 0 sets status bit 0 and reloads the counter from the reload field.
- R7: A mode write with bit 15 clear reloads the counter at once with the written reload value. Mode bit 15 set freezes the counter, and command restarts have no effect while it is set.
- R8: Mode bit 28 freezes counting while dbg_i is high. Mode bit 29 freezes counting while idle_i is high. With those bits clear, the halt inputs have no effect.
- R9: A write to word 0 or word 1 is dropped unless at least GAP_TICKS slow ticks have passed since the last accepted write to either of them.
- R10: A read of word 2 clears both status flags. A flag set in the same cycle as the read stays set.
- R11: irq_o is mode bit 12 ANDed with the OR of the two flags. rst_req_o is a one-cycle pulse in the cycle after a fault, and only when mode bit 13 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | One-cycle enable per slow-clock period |
| dbg_i | input | 1 | Debug halt request |
| idle_i | input | 1 | Idle halt request |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Fault interrupt level |
| rst_req_o | output | 1 | Fault reset request pulse |

## Verification
Some properties are checked on every cycle:
- the counter holds unless a reload or a prescaler wrap occurs, and stays frozen while the watchdog is disabled;
- a decrement at zero raises the underflow flag;
- an accepted write closes the spacing gate;
- the interrupt is never high without a flag set.

Other behaviours appear only through the bench's scenarios, which a per-cycle reference model compares against the outputs: key rejection, early restarts against the window, status read-clear, halt gating and the reset pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CW = 12;
  localparam int AW = 2;
  localparam logic [7:0] KEY = 8'hA5;
  localparam logic [AW-1:0] A_CMD  = 2'd0;
  localparam logic [AW-1:0] A_MODE = 2'd1;
  localparam logic [AW-1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic          hlt_idle;
    logic          hlt_dbg;
    logic [CW-1:0] win;
    logic          dis;
    logic          rst_en;
    logic          irq_en;
    logic [CW-1:0] rld;
  } mode_t;

  function automatic logic [31:0] pack_mode(mode_t m);
    return {2'b00, m.hlt_idle, m.hlt_dbg, m.win, m.dis, 1'b0, m.rst_en, m.irq_en, m.rld};
  endfunction

  function automatic mode_t unpack_mode(logic [31:0] w);
    mode_t m;
    m.rld      = w[11:0];
    m.irq_en   = w[12];
    m.rst_en   = w[13];
    m.dis      = w[15];
    m.win      = w[27:16];
    m.hlt_dbg  = w[28];
    m.hlt_idle = w[29];
    return m;
  endfunction
endpackage

// File: rtl/wdg_gap.sv
module wdg_gap #(
  parameter int GAP_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_tick_i,
  input  logic wr_acc_i,
  output logic ok_o
);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam logic [GW-1:0] GMAX = GW'(GAP_TICKS);

  logic [GW-1:0] cnt_q;

  assign ok_o = (cnt_q == GMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= GMAX;
    else if (wr_acc_i)              cnt_q <= '0;
    else if (slow_tick_i && !ok_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_presc.sv
module wdg_presc #(
  parameter int DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic wrap_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign wrap_o = adv_i && !clr_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (adv_i)  pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          mr_load_i,
  input  logic [CW-1:0] mr_rld_i,
  input  logic          cr_rst_i,
  input  logic [CW-1:0] rld_i,
  input  logic [CW-1:0] win_i,
  input  logic          rd_clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          unf_o,
  output logic          err_o,
  output logic          load_o,
  output logic          fault_o
);
  logic [CW-1:0] cnt_q;
  logic          unf_q, err_q;
  logic          win_ok, unf_set, err_set;

  assign win_ok  = (&win_i) || (cnt_q <= win_i);
  assign load_o  = mr_load_i || (cr_rst_i && win_ok);
  assign err_set = cr_rst_i && !win_ok;
  assign unf_set = dec_i && !load_o && (cnt_q == '0);
  assign fault_o = unf_set || err_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      unf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (mr_load_i)                 cnt_q <= mr_rld_i;
      else if (load_o)               cnt_q <= rld_i;
      else if (dec_i)                cnt_q <= (cnt_q == '0) ? rld_i : cnt_q - 1'b1;
      unf_q <= unf_set || (unf_q && !rd_clr_i);
      err_q <= err_set || (err_q && !rd_clr_i);
    end
  end

  assign cnt_o = cnt_q;
  assign unf_o = unf_q;
  assign err_o = err_q;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int PRESC_DIV = 128,
  parameter int GAP_TICKS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_tick_i,
  input  logic          dbg_i,
  input  logic          idle_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  mode_t         mode_q;
  logic          gap_ok, acc_mr, acc_cr, mr_load, cr_rst, run, rd_clr;
  logic          tick_dec, load, fault, unf, err, rst_req_q;
  logic [CW-1:0] cnt;

  assign acc_mr  = req_i && we_i && (addr_i == A_MODE) && gap_ok;
  assign acc_cr  = req_i && we_i && (addr_i == A_CMD) && gap_ok
                   && (wdata_i[31:24] == KEY) && wdata_i[0];
  assign mr_load = acc_mr && !wdata_i[15];
  assign cr_rst  = acc_cr && !mode_q.dis;
  assign rd_clr  = req_i && !we_i && (addr_i == A_STAT);
  assign run     = !mode_q.dis && !(mode_q.hlt_dbg && dbg_i) && !(mode_q.hlt_idle && idle_i);

  wdg_gap #(.GAP_TICKS(GAP_TICKS)) u_gap (
    .clk_i, .rst_ni, .slow_tick_i,
    .wr_acc_i (acc_mr || acc_cr),
    .ok_o     (gap_ok)
  );

  wdg_presc #(.DIV(PRESC_DIV)) u_presc (
    .clk_i, .rst_ni,
    .clr_i  (load),
    .adv_i  (run && slow_tick_i),
    .wrap_o (tick_dec)
  );

  wdg_core u_core (
    .clk_i, .rst_ni,
    .dec_i     (tick_dec),
    .mr_load_i (mr_load),
    .mr_rld_i  (wdata_i[CW-1:0]),
    .cr_rst_i  (cr_rst),
    .rld_i     (mode_q.rld),
    .win_i     (mode_q.win),
    .rd_clr_i  (rd_clr),
    .cnt_o     (cnt),
    .unf_o     (unf),
    .err_o     (err),
    .load_o    (load),
    .fault_o   (fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '{hlt_idle: 1'b0, hlt_dbg: 1'b0, win: '1, dis: 1'b0,
                     rst_en: 1'b0, irq_en: 1'b0, rld: '1};
      rst_req_q <= 1'b0;
    end else begin
      if (acc_mr) mode_q <= unpack_mode(wdata_i);
      rst_req_q <= fault && mode_q.rst_en;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = pack_mode(mode_q);
      A_STAT:  rdata_o = {4'b0, cnt, 14'b0, err, unf};
      default: rdata_o = '0;
    endcase
  end

  assign irq_o     = mode_q.irq_en && (unf || err);
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_acc_i,
  input logic        gap_ok_i,
  input logic        dis_i,
  input logic        load_i,
  input logic        dec_i,
  input logic [11:0] cnt_i,
  input logic        unf_i,
  input logic        err_i,
  input logic        irq_i
);
  // R9
  a_r9_gap_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc_i |=> !gap_ok_i);
  // R2
  a_r2_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dec_i) |=> $stable(cnt_i));
  // R7
  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i && !load_i) |=> $stable(cnt_i));
  // R6
  a_r6_unf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_i == 12'd0) |=> unf_i);
  // R11
  a_r11_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (unf_i || err_i));
endmodule

bind wdg_top wdg_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_acc_i (acc_mr || acc_cr),
  .gap_ok_i (gap_ok),
  .dis_i    (mode_q.dis),
  .load_i   (load),
  .dec_i    (tick_dec),
  .cnt_i    (cnt),
  .unf_i    (unf),
  .err_i    (err),
  .irq_i    (irq_o)
);

// File: tb/wdg_top_bench.sv
`timescale 1ns/100ps
module wdg_top_bench;
  localparam int DIV = 8;
  localparam int GAP = 3;

  logic        clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, dbg = 1'b0, idle = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  wdg_top #(.PRESC_DIV(DIV), .GAP_TICKS(GAP)) u_wdg_top (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick), .dbg_i(dbg), .idle_i(idle),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  initial forever begin
    @(posedge clk); #1;
    slow_tick = ~slow_tick;
  end

  // reference model
  int m_cnt, m_pre, m_gap, m_rld, m_win;
  bit m_irqen, m_rsten, m_dis, m_hd, m_hi, m_unf, m_err, m_rstq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 4095; m_pre = 0; m_gap = GAP; m_rld = 4095; m_win = 4095;
      m_irqen = 0; m_rsten = 0; m_dis = 0; m_hd = 0; m_hi = 0;
      m_unf = 0; m_err = 0; m_rstq = 0;
    end else begin
      bit acc_mr, acc_cr, run, load, errs, unfs, rdclr;
      int ncnt, npre;
      acc_mr = req && we && addr == 2'd1 && m_gap == GAP;
      acc_cr = req && we && addr == 2'd0 && m_gap == GAP && wdata[31:24] == 8'hA5 && wdata[0];
      run = !m_dis && !(m_hd && dbg) && !(m_hi && idle);
      load = 0; errs = 0; unfs = 0; ncnt = m_cnt; npre = m_pre;
      if (acc_mr && !wdata[15]) begin
        load = 1; ncnt = int'(wdata[11:0]);
      end else if (acc_cr && !m_dis) begin
        if (m_win == 4095 || m_cnt <= m_win) begin load = 1; ncnt = m_rld; end
        else errs = 1;
      end
      if (load) npre = 0;
      else if (run && slow_tick) begin
        if (m_pre == DIV - 1) begin
          npre = 0;
          if (m_cnt == 0) begin unfs = 1; ncnt = m_rld; end
          else ncnt = m_cnt - 1;
        end else npre = m_pre + 1;
      end
      rdclr = req && !we && addr == 2'd2;
      m_unf = unfs || (m_unf && !rdclr);
      m_err = errs || (m_err && !rdclr);
      m_rstq = (unfs || errs) && m_rsten;
      if (acc_mr || acc_cr) m_gap = 0;
      else if (slow_tick && m_gap < GAP) m_gap = m_gap + 1;
      if (acc_mr) begin
        m_rld = int'(wdata[11:0]); m_win = int'(wdata[27:16]);
        m_irqen = wdata[12]; m_rsten = wdata[13]; m_dis = wdata[15];
        m_hd = wdata[28]; m_hi = wdata[29];
      end
      m_cnt = ncnt; m_pre = npre;
    end
  end

  function automatic logic [31:0] exp_rdata(logic [1:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 2'd1)
      r = {2'b0, m_hi, m_hd, m_win[11:0], m_dis, 1'b0, m_rsten, m_irqen, m_rld[11:0]};
    else if (a == 2'd2)
      r = {4'b0, m_cnt[11:0], 14'b0, m_err, m_unf};
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] er;
      bit ei;
      er = exp_rdata(addr);
      ei = m_irqen && (m_unf || m_err);
      compared++;
      if (rdata !== er || irq !== ei || rst_req !== m_rstq) begin
        mismatched++;
        $display("FAIL %s t=%0t rdata=%h/%h irq=%b/%b rst_req=%b/%b (actual/expected)",
                 tag, $time, rdata, er, irq, ei, rst_req, m_rstq);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0; addr = 2'd2;
  endtask

  task automatic rd_stat();
    @(posedge clk); #1;
    req = 1; we = 0; addr = 2'd2;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] mk(int rld, int win, bit ie, bit re, bit dis, bit hd, bit hi);
    return {2'b0, hi, hd, 12'(win), dis, 1'b0, re, ie, 12'(rld)};
  endfunction

  localparam logic [31:0] RESTART = 32'hA500_0001;

  initial begin
    wait_n(3); #1 rst_n = 1;
    tag = "R1"; addr = 2'd1; wait_n(3); #1 addr = 2'd2; wait_n(3);
    tag = "R7"; wr(2'd1, mk(20, 4095, 1, 1, 0, 0, 0)); wait_n(40);
    tag = "R2"; wait_n(100);
    tag = "R6"; wait_n(260);
    tag = "R11"; wait_n(10);
    tag = "R10"; rd_stat(); wait_n(10);
    tag = "R3"; wr(2'd0, 32'h5A00_0001); wait_n(2);
    wr(2'd0, 32'hA500_0000); wait_n(2);
    tag = "R5"; wr(2'd0, RESTART); wait_n(12);
    tag = "R9"; wr(2'd1, mk(30, 4095, 1, 1, 0, 0, 0));
    wr(2'd1, mk(40, 4095, 1, 1, 0, 0, 0)); wait_n(12);
    wr(2'd0, RESTART); wr(2'd0, RESTART); wait_n(12);
    tag = "R4"; wr(2'd1, mk(20, 10, 1, 1, 0, 0, 0)); wait_n(10);
    wr(2'd0, RESTART); wait_n(200);
    wr(2'd0, RESTART); wait_n(12);
    tag = "R10"; rd_stat(); wait_n(4);
    tag = "R8"; wr(2'd1, mk(15, 4095, 1, 0, 0, 1, 1)); wait_n(10);
    #1 dbg = 1; wait_n(60); #1 dbg = 0; idle = 1; wait_n(60); #1 idle = 0; wait_n(40);
    wr(2'd1, mk(15, 4095, 1, 0, 0, 0, 0)); wait_n(10);
    #1 dbg = 1; idle = 1; wait_n(60); #1 dbg = 0; idle = 0;
    tag = "R7"; wr(2'd1, mk(25, 4095, 1, 1, 1, 0, 0)); wait_n(60);
    wr(2'd0, RESTART); wait_n(40);
    tag = "R11"; wr(2'd1, mk(3, 4095, 0, 0, 0, 0, 0)); wait_n(120);
    rd_stat(); wait_n(4);
    wr(2'd1, mk(2, 4095, 1, 1, 0, 0, 0)); wait_n(70);
    wait_n(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait_n(150000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired in %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule